// File: doc/BRIEF.md
# Split-Transaction Isochronous Descriptor Sequencer

This block advances the per-micro-frame state of one isochronous transfer descriptor for a full-speed endpoint that sits behind a high-speed hub's transaction translator. A schedule walker hands it a descriptor snapshot, a 3-bit micro-frame index and a direction flag. The block turns the index into a one-hot frame bit. It tests that bit against the start mask or the complete mask and decides whether a start-split, a complete-split or nothing goes out on the bus. It then presents the updated descriptor for write-back.

For an OUT endpoint each start-split carries one chunk of the payload. The block shrinks the remaining byte count, advances the buffer offset, flips the page selector when the offset wraps past 4 KB, steps the transaction-position code and counts down the chunk counter. The descriptor goes inactive when that counter reaches zero. When enabled, a progress mask records every executed start-split, and a gap in it deactivates the descriptor. An IN descriptor moves to its complete-split phase once its start-split is done. In that phase only the complete mask is consulted.

Top module: `sitd_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, busy, ss_req, cs_req and wb_valid are all low.
- R2: Micro-frame index i selects mask bit i. In the start phase of an active descriptor a start-split is issued only if start-mask bit i is set. If the descriptor is inactive or the bit is clear, no bus request is made and the descriptor is written back unchanged.
- R3: An OUT start-split carries min(remaining bytes, 188) bytes (ss_len) and the descriptor's position code (ss_tp). After bus_done the remaining bytes drop by that length and the 12-bit offset rises by it modulo 4096. The page selector inverts when that addition carries out of bit 11.
- R4: After an OUT start-split the chunk counter decrements. The position code becomes End (2'b11) if one chunk remains, Mid (2'b10) if more remain, and is left unchanged if none remain. The other codes are All 2'b00 and Begin 2'b01.
- R5: After an OUT start-split, Active is cleared exactly when the chunk counter has reached zero. The number of start-splits follows the counter, not the number of start-mask bits set.
- R6: Zero remaining bytes with a chunk counter of one yields one start-split with ss_len 0, followed by an inactive write-back.
- R7: With progress checking on, an executed OUT start-split sets progress-mask bit i. Before issuing, the highest start-mask bit below i, if any, must have its progress bit set. Otherwise no start-split is made, Active is cleared and wb_skip is raised.
- R8: An IN start-split carries ss_len 0. After bus_done the complete-phase flag is set, and the counter, position code, bytes and offset are left unchanged.
- R9: In the complete phase of an active descriptor, cs_req is raised only when complete-mask bit i is set. The descriptor is written back unchanged.
- R10: An OUT start in which the chunk counter is zero, or differs from ceil(bytes/188) (zero bytes counting as one chunk), or whose position code is Begin/Mid with one chunk or All/End with several, raises wb_err with wb_valid. No start-split is made and the descriptor is unchanged.
- R11: Each accepted request gives exactly one single-cycle wb_valid pulse. busy stays high from acceptance until write-back. ss_req and cs_req are never high together, and each is held until bus_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Descriptor snapshot presented (taken when idle) |
| req_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT |
| req_uframe | input | 3 | Current micro-frame index |
| in_active | input | 1 | Descriptor active flag |
| in_csplit | input | 1 | Descriptor is in complete-split phase |
| in_smask | input | 8 | Start-split schedule mask |
| in_cmask | input | 8 | Complete-split schedule mask |
| in_cprog | input | 8 | Progress mask |
| in_tp | input | 2 | Transaction position code |
| in_tcount | input | 3 | Remaining chunk counter |
| in_total | input | 10 | Remaining bytes |
| in_offset | input | 12 | Buffer offset within page |
| in_page | input | 1 | Page selector |
| busy | output | 1 | Request in progress |
| ss_req | output | 1 | Start-split bus request |
| cs_req | output | 1 | Complete-split bus request |
| ss_len | output | 8 | Payload bytes of the start-split |
| ss_tp | output | 2 | Position code sent with the start-split |
| bus_done | input | 1 | Bus transaction finished |
| wb_valid | output | 1 | Write-back fields valid (one cycle) |
| wb_err | output | 1 | Inconsistent descriptor fields |
| wb_skip | output | 1 | Skipped micro-frame detected |
| wb_active | output | 1 | Updated active flag |
| wb_csplit | output | 1 | Updated complete-phase flag |
| wb_cprog | output | 8 | Updated progress mask |
| wb_tp | output | 2 | Updated position code |
| wb_tcount | output | 3 | Updated chunk counter |
| wb_total | output | 10 | Updated remaining bytes |
| wb_offset | output | 12 | Updated offset |
| wb_page | output | 1 | Updated page selector |

## Verification
The bench builds the block with its defaults: a 188-byte chunk limit and progress checking enabled. With the 188-byte limit, a 400-byte transfer takes three chunks through Begin, Mid and End. An offset near 4000 wraps the 4 KB boundary. Exact multiples of the chunk size probe the rounding in the consistency test. Because progress checking is on, a descriptor with a hole in its progress mask exercises the skip path, and chained vectors show the progress mask filling bit by bit.

// File: rtl/sitd_pkg.sv
package sitd_pkg;

    localparam int UF_W  = 3;
    localparam int NUF   = 1 << UF_W;
    localparam int TB_W  = 10;
    localparam int TC_W  = 3;
    localparam int OFF_W = 12;

    typedef enum logic [1:0] {
        TP_ALL   = 2'b00,
        TP_BEGIN = 2'b01,
        TP_MID   = 2'b10,
        TP_END   = 2'b11
    } tpos_e;

    typedef struct packed {
        logic              active;
        logic              csplit;
        logic [NUF-1:0]    smask;
        logic [NUF-1:0]    cmask;
        logic [NUF-1:0]    cprog;
        tpos_e             tp;
        logic [TC_W-1:0]   tcount;
        logic [TB_W-1:0]   total;
        logic [OFF_W-1:0]  offset;
        logic              page;
    } sitd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_SS,
        ST_CS,
        ST_WB
    } seq_st_e;

    function automatic tpos_e next_tp(input logic [TC_W-1:0] left, input tpos_e cur);
        if (left == TC_W'(1))      return TP_END;
        else if (left == '0)       return cur;
        else                       return TP_MID;
    endfunction

endpackage

// File: rtl/sitd_frame_test.sv
module sitd_frame_test
    import sitd_pkg::*;
(
    input  logic [UF_W-1:0] uframe,
    input  logic [NUF-1:0]  smask,
    input  logic [NUF-1:0]  cmask,
    input  logic [NUF-1:0]  cprog,
    output logic [NUF-1:0]  uf_bit,
    output logic            s_hit,
    output logic            c_hit,
    output logic            prev_ok
);

    logic [NUF-1:0] below;
    logic [NUF-1:0] prev_oh;

    for (genvar g = 0; g < NUF; g++) begin : g_dec
        assign uf_bit[g] = (uframe == UF_W'(g));
    end

    assign s_hit = |(uf_bit & smask);
    assign c_hit = |(uf_bit & cmask);
    assign below = smask & (uf_bit - NUF'(1));

    // highest scheduled start bit below the current frame
    always_comb begin
        prev_oh = '0;
        for (int i = 0; i < NUF; i++) begin
            if (below[i]) prev_oh = NUF'(1) << i;
        end
    end

    assign prev_ok = (prev_oh == '0) || (|(prev_oh & cprog));

endmodule

// File: rtl/sitd_out_advance.sv
module sitd_out_advance
    import sitd_pkg::*;
#(
    parameter int CHUNK_MAX  = 188,
    parameter bit PROG_CHECK = 1'b1,
    localparam int LEN_W     = $clog2(CHUNK_MAX + 1)
) (
    input  sitd_t           cur,
    input  logic [NUF-1:0]  uf_bit,
    output logic [LEN_W-1:0] len,
    output logic            consistent,
    output sitd_t           nxt
);

    localparam logic [TB_W:0] CHUNK_W = (TB_W+1)'(CHUNK_MAX);

    logic [TB_W:0]    need;
    logic [OFF_W:0]   sum;
    logic [TB_W-1:0]  len_ext;
    logic [TC_W-1:0]  left;
    logic             tp_ok;

    always_comb begin
        if ({1'b0, cur.total} > CHUNK_W) len = LEN_W'(CHUNK_MAX);
        else                             len = LEN_W'(cur.total);
    end

    assign len_ext = TB_W'(len);

    always_comb begin
        if (cur.total == '0) need = (TB_W+1)'(1);
        else                 need = ({1'b0, cur.total} + CHUNK_W - (TB_W+1)'(1)) / CHUNK_W;
    end

    always_comb begin
        if (cur.tcount == TC_W'(1)) tp_ok = (cur.tp == TP_ALL)   || (cur.tp == TP_END);
        else                        tp_ok = (cur.tp == TP_BEGIN) || (cur.tp == TP_MID);
    end

    assign consistent = (cur.tcount != '0) && (need == (TB_W+1)'(cur.tcount)) && tp_ok;

    assign sum  = {1'b0, cur.offset} + (OFF_W+1)'(len);
    assign left = cur.tcount - TC_W'(1);

    always_comb begin
        nxt        = cur;
        nxt.total  = cur.total - len_ext;
        nxt.offset = sum[OFF_W-1:0];
        nxt.page   = cur.page ^ sum[OFF_W];
        nxt.tcount = left;
        nxt.tp     = next_tp(left, cur.tp);
        nxt.active = (left != '0);
        if (PROG_CHECK) nxt.cprog = cur.cprog | uf_bit;
    end

endmodule

// File: rtl/sitd_sequencer.sv
module sitd_sequencer
    import sitd_pkg::*;
#(
    parameter int CHUNK_MAX  = 188,
    parameter bit PROG_CHECK = 1'b1,
    localparam int LEN_W     = $clog2(CHUNK_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_dir_in,
    input  logic [UF_W-1:0]   req_uframe,
    input  logic              in_active,
    input  logic              in_csplit,
    input  logic [NUF-1:0]    in_smask,
    input  logic [NUF-1:0]    in_cmask,
    input  logic [NUF-1:0]    in_cprog,
    input  logic [1:0]        in_tp,
    input  logic [TC_W-1:0]   in_tcount,
    input  logic [TB_W-1:0]   in_total,
    input  logic [OFF_W-1:0]  in_offset,
    input  logic              in_page,
    output logic              busy,
    output logic              ss_req,
    output logic              cs_req,
    output logic [LEN_W-1:0]  ss_len,
    output logic [1:0]        ss_tp,
    input  logic              bus_done,
    output logic              wb_valid,
    output logic              wb_err,
    output logic              wb_skip,
    output logic              wb_active,
    output logic              wb_csplit,
    output logic [NUF-1:0]    wb_cprog,
    output logic [1:0]        wb_tp,
    output logic [TC_W-1:0]   wb_tcount,
    output logic [TB_W-1:0]   wb_total,
    output logic [OFF_W-1:0]  wb_offset,
    output logic              wb_page
);

    seq_st_e          st;
    sitd_t            cur;
    sitd_t            nxt;
    logic             dir_q;
    logic [UF_W-1:0]  uf_q;
    logic             err_q;
    logic             skip_q;

    logic [NUF-1:0]   uf_bit;
    logic             s_hit;
    logic             c_hit;
    logic             prev_ok;
    logic [LEN_W-1:0] adv_len;
    logic             consistent;

    sitd_frame_test u_test (
        .uframe  (uf_q),
        .smask   (cur.smask),
        .cmask   (cur.cmask),
        .cprog   (cur.cprog),
        .uf_bit  (uf_bit),
        .s_hit   (s_hit),
        .c_hit   (c_hit),
        .prev_ok (prev_ok)
    );

    sitd_out_advance #(
        .CHUNK_MAX  (CHUNK_MAX),
        .PROG_CHECK (PROG_CHECK)
    ) u_adv (
        .cur        (cur),
        .uf_bit     (uf_bit),
        .len        (adv_len),
        .consistent (consistent),
        .nxt        (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cur    <= '0;
            dir_q  <= 1'b0;
            uf_q   <= '0;
            err_q  <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur.active <= in_active;
                        cur.csplit <= in_csplit;
                        cur.smask  <= in_smask;
                        cur.cmask  <= in_cmask;
                        cur.cprog  <= in_cprog;
                        cur.tp     <= tpos_e'(in_tp);
                        cur.tcount <= in_tcount;
                        cur.total  <= in_total;
                        cur.offset <= in_offset;
                        cur.page   <= in_page;
                        dir_q      <= req_dir_in;
                        uf_q       <= req_uframe;
                        err_q      <= 1'b0;
                        skip_q     <= 1'b0;
                        st         <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!cur.active) begin
                        st <= ST_WB;
                    end else if (cur.csplit) begin
                        st <= c_hit ? ST_CS : ST_WB;
                    end else if (!s_hit) begin
                        st <= ST_WB;
                    end else if (dir_q) begin
                        st <= ST_SS;
                    end else if (!consistent) begin
                        err_q <= 1'b1;
                        st    <= ST_WB;
                    end else if (PROG_CHECK && !prev_ok) begin
                        skip_q     <= 1'b1;
                        cur.active <= 1'b0;
                        st         <= ST_WB;
                    end else begin
                        st <= ST_SS;
                    end
                end
                ST_SS: begin
                    if (bus_done) begin
                        if (dir_q) cur.csplit <= 1'b1;
                        else       cur        <= nxt;
                        st <= ST_WB;
                    end
                end
                ST_CS: begin
                    if (bus_done) st <= ST_WB;
                end
                ST_WB: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign ss_req    = (st == ST_SS);
    assign cs_req    = (st == ST_CS);
    assign ss_len    = dir_q ? '0 : adv_len;
    assign ss_tp     = cur.tp;
    assign wb_valid  = (st == ST_WB);
    assign wb_err    = wb_valid & err_q;
    assign wb_skip   = wb_valid & skip_q;
    assign wb_active = cur.active;
    assign wb_csplit = cur.csplit;
    assign wb_cprog  = cur.cprog;
    assign wb_tp     = cur.tp;
    assign wb_tcount = cur.tcount;
    assign wb_total  = cur.total;
    assign wb_offset = cur.offset;
    assign wb_page   = cur.page;

endmodule

// File: rtl/sitd_sequencer_chk.sv
module sitd_sequencer_chk #(
    parameter int CHUNK_MAX = 188,
    parameter int LEN_W     = 8,
    parameter int TC_W      = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             ss_req,
    input logic             cs_req,
    input logic [LEN_W-1:0] ss_len,
    input logic             bus_done,
    input logic             wb_valid,
    input logic             wb_err,
    input logic             wb_skip,
    input logic             wb_active,
    input logic             wb_csplit,
    input logic [TC_W-1:0]  wb_tcount
);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!busy && !ss_req && !cs_req && !wb_valid));

    a_r11_one_bus_req: assert property (@(posedge clk) disable iff (rst)
        !(ss_req && cs_req));

    a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
        (ss_req && !bus_done) |=> (ss_req && $stable(ss_len)));

    a_r11_wb_pulse: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid);

    a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
        ss_req |-> (int'(ss_len) <= CHUNK_MAX));

    a_r5_active_tracks_count: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && $past(ss_req) && !wb_csplit) |-> (wb_active == (wb_tcount != '0)));

    a_r7_skip_deactivates: assert property (@(posedge clk) disable iff (rst)
        wb_skip |-> !wb_active);

    a_r9_cs_in_phase: assert property (@(posedge clk) disable iff (rst)
        cs_req |-> (wb_csplit && wb_active));

    a_r10_err_with_wb: assert property (@(posedge clk) disable iff (rst)
        wb_err |-> (wb_valid && !$past(ss_req)));

endmodule

bind sitd_sequencer sitd_sequencer_chk #(
    .CHUNK_MAX (CHUNK_MAX),
    .LEN_W     (LEN_W),
    .TC_W      (sitd_pkg::TC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .ss_req    (ss_req),
    .cs_req    (cs_req),
    .ss_len    (ss_len),
    .bus_done  (bus_done),
    .wb_valid  (wb_valid),
    .wb_err    (wb_err),
    .wb_skip   (wb_skip),
    .wb_active (wb_active),
    .wb_csplit (wb_csplit),
    .wb_tcount (wb_tcount)
);

// File: tb/sitd_sequencer_tb.sv
`timescale 1ns/1ps
module sitd_sequencer_tb;

    typedef struct packed {
        logic        dir;
        logic [2:0]  uf;
        logic        active;
        logic        csplit;
        logic [7:0]  smask;
        logic [7:0]  cmask;
        logic [7:0]  cprog;
        logic [1:0]  tp;
        logic [2:0]  tcount;
        logic [9:0]  total;
        logic [11:0] offset;
        logic        page;
    } vec_t;

    typedef struct packed {
        logic [1:0]  act;    // 0 none, 1 start, 2 complete
        logic [7:0]  len;
        logic [1:0]  sstp;
        logic        err;
        logic        skip;
        logic        active;
        logic        csplit;
        logic [7:0]  cprog;
        logic [1:0]  tp;
        logic [2:0]  tcount;
        logic [9:0]  total;
        logic [11:0] offset;
        logic        page;
    } exp_t;

    function automatic vec_t mk(input logic d, input logic [2:0] u, input logic a, input logic c,
                                input logic [7:0] sm, input logic [7:0] cm, input logic [7:0] cp,
                                input logic [1:0] t, input logic [2:0] tc, input logic [9:0] tot,
                                input logic [11:0] off, input logic pg);
        vec_t v;
        v.dir = d; v.uf = u; v.active = a; v.csplit = c; v.smask = sm; v.cmask = cm;
        v.cprog = cp; v.tp = t; v.tcount = tc; v.total = tot; v.offset = off; v.page = pg;
        return v;
    endfunction

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        mk(0, 3'd0, 1, 0, 8'h01, 8'h00, 8'h00, 2'd0, 3'd1, 10'd100, 12'd0,    0), // R3 single chunk
        mk(0, 3'd0, 1, 0, 8'h0F, 8'h00, 8'h00, 2'd1, 3'd3, 10'd400, 12'd0,    0), // R4 Begin
        mk(0, 3'd1, 1, 0, 8'h0F, 8'h00, 8'h01, 2'd2, 3'd2, 10'd212, 12'd188,  0), // R4 Mid
        mk(0, 3'd2, 1, 0, 8'h0F, 8'h00, 8'h03, 2'd3, 3'd1, 10'd24,  12'd376,  0), // R5 End
        mk(0, 3'd3, 1, 0, 8'h08, 8'h00, 8'h00, 2'd0, 3'd1, 10'd150, 12'd4000, 0), // R3 page wrap
        mk(0, 3'd5, 1, 0, 8'h20, 8'h00, 8'h00, 2'd0, 3'd1, 10'd0,   12'd0,    0), // R6 zero length
        mk(0, 3'd2, 1, 0, 8'h01, 8'h00, 8'h00, 2'd0, 3'd1, 10'd10,  12'd0,    0), // R2 mask miss
        mk(0, 3'd0, 0, 0, 8'h01, 8'h00, 8'h00, 2'd0, 3'd1, 10'd10,  12'd0,    0), // R2 inactive
        mk(0, 3'd2, 1, 0, 8'h07, 8'h00, 8'h01, 2'd2, 3'd2, 10'd300, 12'd188,  0), // R7 skip
        mk(1, 3'd4, 1, 0, 8'h10, 8'h0C, 8'h00, 2'd0, 3'd1, 10'd0,   12'd0,    0), // R8 IN start
        mk(1, 3'd3, 1, 1, 8'h10, 8'h0C, 8'h00, 2'd0, 3'd1, 10'd0,   12'd0,    0), // R9 hit
        mk(1, 3'd5, 1, 1, 8'h10, 8'h0C, 8'h00, 2'd0, 3'd1, 10'd0,   12'd0,    0), // R9 miss
        mk(0, 3'd0, 1, 0, 8'h01, 8'h00, 8'h00, 2'd1, 3'd2, 10'd100, 12'd0,    0), // R10 count
        mk(0, 3'd0, 1, 0, 8'h01, 8'h00, 8'h00, 2'd1, 3'd1, 10'd100, 12'd0,    0), // R10 code
        mk(0, 3'd6, 1, 0, 8'hFF, 8'h00, 8'h3F, 2'd3, 3'd1, 10'd50,  12'd0,    0), // R5 many mask bits
        mk(0, 3'd7, 1, 0, 8'h80, 8'h00, 8'h00, 2'd1, 3'd2, 10'd376, 12'd0,    1), // R4 exact chunks
        mk(0, 3'd0, 1, 0, 8'h01, 8'h00, 8'h00, 2'd0, 3'd0, 10'd0,   12'd0,    0), // R10 zero count
        mk(0, 3'd1, 1, 0, 8'h02, 8'h00, 8'h00, 2'd0, 3'd1, 10'd188, 12'd100,  0)  // R3 full chunk
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_dir_in = 1'b0;
    logic [2:0]  req_uframe = '0;
    logic        in_active = 1'b0, in_csplit = 1'b0, in_page = 1'b0;
    logic [7:0]  in_smask = '0, in_cmask = '0, in_cprog = '0;
    logic [1:0]  in_tp = '0;
    logic [2:0]  in_tcount = '0;
    logic [9:0]  in_total = '0;
    logic [11:0] in_offset = '0;
    logic        bus_done = 1'b0;

    logic        busy, ss_req, cs_req, wb_valid, wb_err, wb_skip, wb_active, wb_csplit, wb_page;
    logic [7:0]  ss_len, wb_cprog;
    logic [1:0]  ss_tp, wb_tp;
    logic [2:0]  wb_tcount;
    logic [9:0]  wb_total;
    logic [11:0] wb_offset;

    int total_checks = 0;
    int bad_checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sitd_sequencer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dir_in(req_dir_in),
        .req_uframe(req_uframe), .in_active(in_active), .in_csplit(in_csplit),
        .in_smask(in_smask), .in_cmask(in_cmask), .in_cprog(in_cprog), .in_tp(in_tp),
        .in_tcount(in_tcount), .in_total(in_total), .in_offset(in_offset), .in_page(in_page),
        .busy(busy), .ss_req(ss_req), .cs_req(cs_req), .ss_len(ss_len), .ss_tp(ss_tp),
        .bus_done(bus_done), .wb_valid(wb_valid), .wb_err(wb_err), .wb_skip(wb_skip),
        .wb_active(wb_active), .wb_csplit(wb_csplit), .wb_cprog(wb_cprog), .wb_tp(wb_tp),
        .wb_tcount(wb_tcount), .wb_total(wb_total), .wb_offset(wb_offset), .wb_page(wb_page)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total_checks++;
        if (act !== exp) begin
            bad_checks++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model built from the requirement text
    function automatic exp_t model(input vec_t v);
        exp_t e;
        logic [7:0] ufb;
        int need, pi, sum;
        logic bad;
        e = '0;
        e.active = v.active; e.csplit = v.csplit; e.cprog = v.cprog; e.tp = v.tp;
        e.tcount = v.tcount; e.total = v.total; e.offset = v.offset; e.page = v.page;
        ufb = 8'h01 << v.uf;
        if (!v.active) return e;
        if (v.csplit) begin
            if ((v.cmask & ufb) != 0) e.act = 2'd2;
            return e;
        end
        if ((v.smask & ufb) == 0) return e;
        if (v.dir) begin
            e.act = 2'd1; e.len = 0; e.sstp = v.tp; e.csplit = 1'b1;
            return e;
        end
        need = (v.total == 0) ? 1 : (int'(v.total) + 187) / 188;
        bad = (v.tcount == 0) || (need != int'(v.tcount)) ||
              ((v.tcount == 1) ? (v.tp == 2'd1 || v.tp == 2'd2) : (v.tp == 2'd0 || v.tp == 2'd3));
        if (bad) begin
            e.err = 1'b1;
            return e;
        end
        pi = -1;
        for (int i = 0; i < 8; i++) if (i < int'(v.uf) && v.smask[i]) pi = i;
        if (pi >= 0 && !v.cprog[pi]) begin
            e.skip = 1'b1; e.active = 1'b0;
            return e;
        end
        e.act = 2'd1;
        e.len = (v.total > 188) ? 8'd188 : v.total[7:0];
        e.sstp = v.tp;
        e.total = v.total - 10'(e.len);
        sum = int'(v.offset) + int'(e.len);
        if (sum >= 4096) begin
            e.offset = 12'(sum - 4096); e.page = ~v.page;
        end else begin
            e.offset = 12'(sum);
        end
        e.tcount = v.tcount - 3'd1;
        if (e.tcount == 3'd1) e.tp = 2'd3;
        else if (e.tcount != 3'd0) e.tp = 2'd2;
        e.active = (e.tcount != 0);
        e.cprog = v.cprog | ufb;
        return e;
    endfunction

    task automatic run_vec(input vec_t v, output logic [1:0] act, output logic [7:0] len,
                           output logic [1:0] sstp, output int n_wb, output int n_req);
        bit got;
        act = 2'd0; len = 8'hFF; sstp = 2'd0; n_wb = 0; n_req = 0; got = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_dir_in = v.dir; req_uframe = v.uf; in_active = v.active;
        in_csplit = v.csplit; in_smask = v.smask; in_cmask = v.cmask; in_cprog = v.cprog;
        in_tp = v.tp; in_tcount = v.tcount; in_total = v.total; in_offset = v.offset;
        in_page = v.page;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 busy after accept", 32'(busy), 32'd1);
        for (int k = 0; k < 20 && !got; k++) begin
            @(negedge clk);
            bus_done = 1'b0;
            if (ss_req && cs_req) check("R11 exclusive requests", 32'd1, 32'd0);
            if (wb_valid) begin
                got = 1'b1;
                n_wb++;
            end else if (ss_req) begin
                act = 2'd1; len = ss_len; sstp = ss_tp; n_req++; bus_done = 1'b1;
            end else if (cs_req) begin
                act = 2'd2; n_req++; bus_done = 1'b1;
            end
        end
        if (!got) check("R11 write-back seen", 32'd0, 32'd1);
    endtask

    task automatic check_wb(input exp_t e);
        check("R10 err flag",      32'(wb_err),    32'(e.err));
        check("R7 skip flag",      32'(wb_skip),   32'(e.skip));
        check("R5 active",         32'(wb_active), 32'(e.active));
        check("R8 phase flag",     32'(wb_csplit), 32'(e.csplit));
        check("R7 progress mask",  32'(wb_cprog),  32'(e.cprog));
        check("R4 position code",  32'(wb_tp),     32'(e.tp));
        check("R4 chunk counter",  32'(wb_tcount), 32'(e.tcount));
        check("R3 bytes left",     32'(wb_total),  32'(e.total));
        check("R3 offset",         32'(wb_offset), 32'(e.offset));
        check("R3 page select",    32'(wb_page),   32'(e.page));
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total_checks++;
            bad_checks++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] act;
        logic [7:0] len;
        logic [1:0] sstp;
        int n_wb, n_req;
        exp_t e;
        vec_t v;

        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1 busy",     32'(busy),     32'd0);
        check("R1 ss_req",   32'(ss_req),   32'd0);
        check("R1 cs_req",   32'(cs_req),   32'd0);
        check("R1 wb_valid", 32'(wb_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after release", 32'(busy), 32'd0);

        for (int n = 0; n < NV; n++) begin
            e = model(VECS[n]);
            run_vec(VECS[n], act, len, sstp, n_wb, n_req);
            check("R2 R9 bus action", 32'(act), 32'(e.act));
            check("R11 single write-back", 32'(n_wb), 32'd1);
            if (e.act == 2'd1) begin
                check("R3 start length", 32'(len),  32'(e.len));
                check("R3 start position", 32'(sstp), 32'(e.sstp));
            end
            check_wb(e);
            @(negedge clk);
            check("R11 wb one cycle", 32'(wb_valid), 32'd0);
        end

        // R6: zero bytes with one chunk gives one empty start-split
        v = mk(0, 3'd4, 1, 0, 8'h10, 8'h00, 8'h00, 2'd0, 3'd1, 10'd0, 12'd20, 0);
        run_vec(v, act, len, sstp, n_wb, n_req);
        check("R6 one start",     32'(n_req),     32'd1);
        check("R6 empty payload", 32'(len),       32'd0);
        check("R6 deactivated",   32'(wb_active), 32'd0);

        // R5: three chunks on a full mask need exactly three starts
        begin
            vec_t w;
            int starts;
            starts = 0;
            w = mk(0, 3'd0, 1, 0, 8'hFF, 8'h00, 8'h00, 2'd1, 3'd3, 10'd500, 12'd0, 0);
            for (int f = 0; f < 8; f++) begin
                w.uf = 3'(f);
                run_vec(w, act, len, sstp, n_wb, n_req);
                starts += n_req;
                w.active = wb_active; w.cprog = wb_cprog; w.tp = wb_tp;
                w.tcount = wb_tcount; w.total = wb_total; w.offset = wb_offset; w.page = wb_page;
            end
            check("R5 start count", 32'(starts),   32'd3);
            check("R5 final active", 32'(w.active), 32'd0);
            check("R5 final bytes",  32'(w.total),  32'd0);
        end

        // R11: request ignored while busy
        v = mk(1, 3'd2, 1, 1, 8'h00, 8'h04, 8'h00, 2'd0, 3'd1, 10'd0, 12'd0, 0);
        @(negedge clk);
        req_valid = 1'b1; req_dir_in = 1'b1; req_uframe = 3'd2; in_active = 1'b1;
        in_csplit = 1'b1; in_cmask = 8'h04; in_smask = 8'h00;
        @(negedge clk);
        req_valid = 1'b1; req_uframe = 3'd0;   // should not be taken
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 held request", 32'(cs_req), 32'd1);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        check("R9 complete write-back", 32'(wb_valid), 32'd1);
        @(negedge clk);
        check("R11 back to idle", 32'(busy), 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule